// File: doc/BRIEF.md
# TLB Management Register Interface

This block holds the software-visible control registers of a translation buffer. Software never addresses a buffer entry directly. It loads an index register, and accesses to the entry-tag and entry-data windows then read or write the selected entry. Beside the tag and data words, the block keeps an 8-bit owner id (the entry tag id) for each entry. It also holds the current process id and a zone protection word.

Some accesses have side effects. Writing a tag copies the current process id into that entry's tag id. Reading a tag loads the process id with that entry's tag id. Writing the search register starts an associative lookup that takes a fixed number of cycles. When the lookup ends, it stores either the matching index or a miss flag in the index register.

Two elaboration parameters gate all accesses: the MMU mode and the access level. Rejected accesses raise a one-cycle strobe. A separate invalidate pulse tells the translation cache to drop either one entry or everything.

Top module: `tlb_mgmt_regs`

## Requirements
- R1: After reset, every register (index, process id, zone word, and every entry's tag, data and tag id) is zero. `busy`, the strobes and the invalidate pulse are low.
- R2: `acc_sel` encodes 0 = entry data, 1 = entry tag, 2 = index, 3 = search, 4 = process id, 5 = zone word. The low log2(ENTRIES) bits of the index select the entry for codes 0 and 1. Read data appears on `rd_data` in the cycle after the read is accepted and is zero in every other cycle.
- R3: A tag write stores process id bits 7:0 as that entry's tag id. A tag read returns the tag word and loads the process id with that entry's tag id.
- R4: The tag word layout is valid = bit 6. If a tag write lands on an entry whose old tag had bit 6 set, `inv_valid` pulses one cycle later with `inv_all` = 0 and `inv_idx` = the entry. If the old tag had bit 6 clear, there is no pulse.
- R5: A search write raises `busy` for SEARCH_CYCLES cycles. At the edge where `busy` falls, the index takes the lowest hitting entry number. On a miss, index bit 31 is set and its other bits are kept.
- R6: An entry hits when all three of these hold: tag bit 6 is set; the page number (bits 31:10) of the written value equals the tag's bits 31:10 above the page offset, where the page size is 1 KiB × 4^code with code = tag bits 9:7; and the tag id is zero or equals process id bits 7:0.
- R7: The entry data bits 7:4 select zone z, whose 2-bit field in the zone word is bits (31-2z):(30-2z). A field of 0 turns the entry into a miss for a search issued in user mode (`priv_user` = 1, sampled at the search write). A zone number of ZONES or above acts as field 1.
- R8: An access presented while `busy` is high has no effect and raises no strobe.
- R9: If MMU_MODE < 2 or ACCESS_LVL = 0, every read returns zero, every write is ignored, and `acc_illegal` pulses for each access.
- R10: If ACCESS_LVL bit 0 is clear, reads of codes 0, 1, 4 and 5 return zero and pulse `acc_illegal`. If ACCESS_LVL ≤ 1, writes of codes 3, 4 and 5 are ignored and pulse `acc_illegal`.
- R11: A write to the process id or the zone word with a value different from the stored one pulses `inv_valid` with `inv_all` = 1. Writing an equal value gives no pulse.
- R12: A process id write with any of bits 31:8 set pulses `pid_range_err`. The value is still stored.
- R13: Codes 6 and 7 read as zero, change nothing, and pulse `acc_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access request, one cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 3 | Register select code |
| acc_wdata | input | 32 | Write value |
| priv_user | input | 1 | 1 = user mode for a search |
| rd_data | output | 32 | Read result, cycle after the read |
| busy | output | 1 | Search in progress |
| acc_illegal | output | 1 | Access rejected by configuration |
| inv_valid | output | 1 | Drop cached translations |
| inv_all | output | 1 | Invalidate covers all entries |
| inv_idx | output | 8 | Entry to drop when `inv_all` = 0 |
| pid_range_err | output | 1 | Process id written above 8 bits |

## Verification
Read data, `acc_illegal`, `pid_range_err` and the invalidate pulse are registered, so they are due in the cycle after the edge that accepts the access. The bench drives each access on a falling edge and samples on the next falling edge. A search raises `busy` at the edge that accepts it, and the index updates SEARCH_CYCLES edges later. The bench checks that `busy` is still high one falling edge before that point and low right after it. Only then does it read the index back through the normal read path.

// File: rtl/tlbreg_pkg.sv
`timescale 1ns/1ps
package tlbreg_pkg;
    localparam logic [2:0] SEL_DATA = 3'd0;
    localparam logic [2:0] SEL_TAG  = 3'd1;
    localparam logic [2:0] SEL_IDX  = 3'd2;
    localparam logic [2:0] SEL_SRCH = 3'd3;
    localparam logic [2:0] SEL_PID  = 3'd4;
    localparam logic [2:0] SEL_ZONE = 3'd5;

    localparam int VALID_BIT = 6;
    localparam int MISS_BIT  = 31;

    typedef struct packed {
        logic [31:0] pid;
        logic [31:0] zone;
        logic [31:0] idx;
        logic [31:0] rd;
        logic        ill;
        logic        inv;
        logic        inv_all;
        logic [7:0]  inv_idx;
        logic        perr;
    } ctl_regs_t;

    // Page mask on address bits 31:10 for a size code (1 KiB * 4^code).
    function automatic logic [21:0] page_mask(input logic [2:0] code);
        return 22'h3FFFFF << {code, 1'b0};
    endfunction
endpackage

// File: rtl/tlb_entry_match.sv
`timescale 1ns/1ps
module tlb_entry_match #(
    parameter int ZONES = 16
) (
    input  logic [21:0] tag_page,
    input  logic [2:0]  tag_code,
    input  logic        tag_valid,
    input  logic [3:0]  zone_sel,
    input  logic [7:0]  owner,
    input  logic [21:0] key_page,
    input  logic [7:0]  cur_pid,
    input  logic [31:0] zone_word,
    input  logic        user,
    output logic        hit
);
    import tlbreg_pkg::*;

    localparam logic [4:0] ZLIM = 5'(ZONES);

    logic [21:0] mask;
    logic        page_eq;
    logic        owner_ok;
    logic [4:0]  shamt;
    logic [31:0] zshift;
    logic [1:0]  zfield;

    always_comb begin
        mask     = page_mask(tag_code);
        page_eq  = ((key_page ^ tag_page) & mask) == '0;
        owner_ok = (owner == 8'd0) || (owner == cur_pid);
        shamt    = 5'd30 - {zone_sel, 1'b0};
        zshift   = zone_word >> shamt;
        zfield   = ({1'b0, zone_sel} >= ZLIM) ? 2'd1 : zshift[1:0];
        hit      = tag_valid && page_eq && owner_ok && !(zfield == 2'd0 && user);
    end
endmodule

// File: rtl/tlb_search_unit.sv
`timescale 1ns/1ps
module tlb_search_unit #(
    parameter int ENTRIES       = 16,
    parameter int ZONES         = 16,
    parameter int SEARCH_CYCLES = 4,
    localparam int IW = $clog2(ENTRIES),
    localparam int CW = $clog2(SEARCH_CYCLES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [21:0]              key_page,
    input  logic                     user,
    input  logic [7:0]               cur_pid,
    input  logic [31:0]              zone_word,
    input  logic [ENTRIES-1:0][31:0] tags,
    input  logic [ENTRIES-1:0][3:0]  zsels,
    input  logic [ENTRIES-1:0][7:0]  owners,
    output logic                     busy,
    output logic                     done,
    output logic                     found,
    output logic [IW-1:0]            found_idx
);
    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [21:0]   key;
        logic          user;
    } srch_t;

    srch_t s_d, s_q;
    logic [ENTRIES-1:0] hits;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        tlb_entry_match #(.ZONES(ZONES)) u_match (
            .tag_page (tags[g][31:10]),
            .tag_code (tags[g][9:7]),
            .tag_valid(tags[g][6]),
            .zone_sel (zsels[g]),
            .owner    (owners[g]),
            .key_page (s_q.key),
            .cur_pid  (cur_pid),
            .zone_word(zone_word),
            .user     (s_q.user),
            .hit      (hits[g])
        );
    end

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CW'(SEARCH_CYCLES - 1);
            s_d.key  = key_page;
            s_d.user = user;
        end else if (s_q.busy) begin
            if (s_q.cnt == '0) s_d.busy = 1'b0;
            else               s_d.cnt  = s_q.cnt - 1'b1;
        end
    end

    always_comb begin
        found     = |hits;
        found_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) found_idx = IW'(i);
        end
    end

    assign busy = s_q.busy;
    assign done = s_q.busy && (s_q.cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !s_q.busy);
    assert_done_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/tlb_mgmt_regs.sv
`timescale 1ns/1ps
module tlb_mgmt_regs #(
    parameter int ENTRIES       = 16,
    parameter int ZONES         = 16,
    parameter int MMU_MODE      = 3,
    parameter int ACCESS_LVL    = 3,
    parameter int SEARCH_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [2:0]  acc_sel,
    input  logic [31:0] acc_wdata,
    input  logic        priv_user,
    output logic [31:0] rd_data,
    output logic        busy,
    output logic        acc_illegal,
    output logic        inv_valid,
    output logic        inv_all,
    output logic [7:0]  inv_idx,
    output logic        pid_range_err
);
    import tlbreg_pkg::*;

    localparam int IW        = $clog2(ENTRIES);
    localparam bit ENABLED   = (MMU_MODE >= 2) && (ACCESS_LVL != 0);
    localparam bit RD_OK     = (ACCESS_LVL % 2) == 1;
    localparam bit WR_OK     = ACCESS_LVL > 1;

    ctl_regs_t r_d, r_q;

    logic [ENTRIES-1:0][31:0] tag_q, data_q;
    logic [ENTRIES-1:0][7:0]  tid_q;
    logic [ENTRIES-1:0][3:0]  zsel_w;
    logic [IW-1:0]            esel;
    logic                     tag_we, data_we, srch_start, take;
    logic                     srch_done, srch_found;
    logic [IW-1:0]            srch_idx;

    assign esel = r_q.idx[IW-1:0];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_zsel
        assign zsel_w[g] = data_q[g][7:4];
    end

    tlb_search_unit #(
        .ENTRIES(ENTRIES), .ZONES(ZONES), .SEARCH_CYCLES(SEARCH_CYCLES)
    ) u_search (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (srch_start),
        .key_page (acc_wdata[31:10]),
        .user     (priv_user),
        .cur_pid  (r_q.pid[7:0]),
        .zone_word(r_q.zone),
        .tags     (tag_q),
        .zsels    (zsel_w),
        .owners   (tid_q),
        .busy     (busy),
        .done     (srch_done),
        .found    (srch_found),
        .found_idx(srch_idx)
    );

    always_comb begin
        r_d         = r_q;
        r_d.rd      = '0;
        r_d.ill     = 1'b0;
        r_d.inv     = 1'b0;
        r_d.inv_all = 1'b0;
        r_d.inv_idx = '0;
        r_d.perr    = 1'b0;
        tag_we      = 1'b0;
        data_we     = 1'b0;
        srch_start  = 1'b0;
        take        = acc_valid && !busy;

        if (take) begin
            if (!ENABLED) begin
                r_d.ill = 1'b1;
            end else if (acc_write) begin
                case (acc_sel)
                    SEL_DATA: data_we = 1'b1;
                    SEL_TAG: begin
                        tag_we = 1'b1;
                        if (tag_q[esel][VALID_BIT]) begin
                            r_d.inv     = 1'b1;
                            r_d.inv_idx = 8'(esel);
                        end
                    end
                    SEL_IDX: r_d.idx = acc_wdata;
                    SEL_SRCH: begin
                        if (WR_OK) srch_start = 1'b1;
                        else       r_d.ill    = 1'b1;
                    end
                    SEL_PID: begin
                        if (WR_OK) begin
                            if (acc_wdata != r_q.pid) begin
                                r_d.inv     = 1'b1;
                                r_d.inv_all = 1'b1;
                            end
                            r_d.pid  = acc_wdata;
                            r_d.perr = |acc_wdata[31:8];
                        end else begin
                            r_d.ill = 1'b1;
                        end
                    end
                    SEL_ZONE: begin
                        if (WR_OK) begin
                            if (acc_wdata != r_q.zone) begin
                                r_d.inv     = 1'b1;
                                r_d.inv_all = 1'b1;
                            end
                            r_d.zone = acc_wdata;
                        end else begin
                            r_d.ill = 1'b1;
                        end
                    end
                    default: r_d.ill = 1'b1;
                endcase
            end else begin
                case (acc_sel)
                    SEL_DATA: begin
                        if (RD_OK) r_d.rd  = data_q[esel];
                        else       r_d.ill = 1'b1;
                    end
                    SEL_TAG: begin
                        if (RD_OK) begin
                            r_d.rd  = tag_q[esel];
                            r_d.pid = {24'd0, tid_q[esel]};
                        end else begin
                            r_d.ill = 1'b1;
                        end
                    end
                    SEL_IDX:  r_d.rd = r_q.idx;
                    SEL_SRCH: r_d.rd = '0;
                    SEL_PID: begin
                        if (RD_OK) r_d.rd  = r_q.pid;
                        else       r_d.ill = 1'b1;
                    end
                    SEL_ZONE: begin
                        if (RD_OK) r_d.rd  = r_q.zone;
                        else       r_d.ill = 1'b1;
                    end
                    default: r_d.ill = 1'b1;
                endcase
            end
        end

        if (srch_done) begin
            if (srch_found) r_d.idx = 32'(srch_idx);
            else            r_d.idx = r_q.idx | (32'd1 << MISS_BIT);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            data_q <= '0;
            tid_q  <= '0;
        end else begin
            if (tag_we) begin
                tag_q[esel] <= acc_wdata;
                tid_q[esel] <= r_q.pid[7:0];
            end
            if (data_we) data_q[esel] <= acc_wdata;
        end
    end

    assign rd_data       = r_q.rd;
    assign acc_illegal   = r_q.ill;
    assign inv_valid     = r_q.inv;
    assign inv_all       = r_q.inv_all;
    assign inv_idx       = r_q.inv_idx;
    assign pid_range_err = r_q.perr;

    assert_inv_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> $past(acc_valid && acc_write));
    assert_illegal_after_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_illegal |-> $past(acc_valid));
    assert_busy_from_search_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(acc_valid && acc_write && acc_sel == SEL_SRCH));
    assert_pid_err_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pid_range_err |-> $past(acc_wdata[31:8] != 24'd0));
    assert_idx_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !$past(srch_done)) |-> $stable(r_q.idx));
    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ENABLED |-> (!inv_valid && !busy && rd_data == 32'd0));
endmodule

// File: tb/tb_tlb_mgmt_regs.sv
`timescale 1ns/1ps
module tb_tlb_mgmt_regs;
    localparam int SC = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, acc_valid, acc_write, priv_user;
    logic [2:0]  acc_sel;
    logic [31:0] acc_wdata;

    logic [31:0] rd_a, rd_o, rd_1, rd_2;
    logic        busy_a, busy_o, busy_1, busy_2;
    logic        ill_a, ill_o, ill_1, ill_2;
    logic        inv_a, inv_o, inv_1, inv_2;
    logic        iall_a, iall_o, iall_1, iall_2;
    logic [7:0]  iidx_a, iidx_o, iidx_1, iidx_2;
    logic        perr_a, perr_o, perr_1, perr_2;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    tlb_mgmt_regs #(.ENTRIES(16), .ZONES(4), .MMU_MODE(3), .ACCESS_LVL(3), .SEARCH_CYCLES(SC)) dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write), .acc_sel(acc_sel),
        .acc_wdata(acc_wdata), .priv_user(priv_user), .rd_data(rd_a), .busy(busy_a),
        .acc_illegal(ill_a), .inv_valid(inv_a), .inv_all(iall_a), .inv_idx(iidx_a), .pid_range_err(perr_a));
    tlb_mgmt_regs #(.MMU_MODE(1)) dut_off (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write), .acc_sel(acc_sel),
        .acc_wdata(acc_wdata), .priv_user(priv_user), .rd_data(rd_o), .busy(busy_o),
        .acc_illegal(ill_o), .inv_valid(inv_o), .inv_all(iall_o), .inv_idx(iidx_o), .pid_range_err(perr_o));
    tlb_mgmt_regs #(.ACCESS_LVL(1)) dut_l1 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write), .acc_sel(acc_sel),
        .acc_wdata(acc_wdata), .priv_user(priv_user), .rd_data(rd_1), .busy(busy_1),
        .acc_illegal(ill_1), .inv_valid(inv_1), .inv_all(iall_1), .inv_idx(iidx_1), .pid_range_err(perr_1));
    tlb_mgmt_regs #(.ZONES(4), .ACCESS_LVL(2), .SEARCH_CYCLES(SC)) dut_l2 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write), .acc_sel(acc_sel),
        .acc_wdata(acc_wdata), .priv_user(priv_user), .rd_data(rd_2), .busy(busy_2),
        .acc_illegal(ill_2), .inv_valid(inv_2), .inv_all(iall_2), .inv_idx(iidx_2), .pid_range_err(perr_2));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_sel = s; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_sel = 3'd0; acc_wdata = 32'd0;
    endtask

    task automatic search(input logic [31:0] key, input logic u, input logic [31:0] exp_idx,
                          input string tag);
        priv_user = u;
        acc(1'b1, 3'd3, key);
        chk({tag, " busy raised"}, 32'(busy_a), 32'd1);
        repeat (SC - 1) @(negedge clk);
        chk({tag, " busy held"}, 32'(busy_a), 32'd1);
        @(negedge clk);
        chk({tag, " busy dropped"}, 32'(busy_a), 32'd0);
        acc(1'b0, 3'd2, 32'd0);
        chk(tag, rd_a, exp_idx);
    endtask

    task automatic t_reset;
        chk("R1 busy after reset", 32'(busy_a), 32'd0);
        chk("R1 strobe after reset", 32'({ill_a, inv_a, perr_a}), 32'd0);
        for (int s = 0; s < 6; s++) begin
            acc(1'b0, 3'(s), 32'd0);
            chk($sformatf("R1 reset read sel %0d", s), rd_a, 32'd0);
        end
    endtask

    task automatic t_entry_rw;
        acc(1'b1, 3'd2, 32'd3);
        acc(1'b1, 3'd0, 32'hAAAA_5500);
        acc(1'b0, 3'd0, 32'd0);
        chk("R2 data readback entry 3", rd_a, 32'hAAAA_5500);
        chk("R9 off read zero", rd_o, 32'd0);
        chk("R9 off read strobe", 32'(ill_o), 32'd1);
        chk("R10 level2 data read zero", rd_2, 32'd0);
        chk("R10 level2 data read strobe", 32'(ill_2), 32'd1);
        acc(1'b1, 3'd2, 32'd5);
        acc(1'b0, 3'd0, 32'd0);
        chk("R2 other entry empty", rd_a, 32'd0);
        acc(1'b1, 3'd2, 32'h13);
        acc(1'b0, 3'd0, 32'd0);
        chk("R2 index wraps to low bits", rd_a, 32'hAAAA_5500);
        acc(1'b0, 3'd2, 32'd0);
        chk("R2 index readback", rd_a, 32'h13);
        chk("R10 level2 index read allowed", rd_2, 32'h13);
        chk("R10 level2 index read no strobe", 32'(ill_2), 32'd0);
        @(negedge clk);
        chk("R2 rd_data zero when idle", rd_a, 32'd0);
    endtask

    task automatic t_tid_pid;
        acc(1'b1, 3'd4, 32'h42);
        chk("R11 pid change invalidates", 32'({inv_a, iall_a}), 32'd3);
        chk("R10 level1 pid write rejected", 32'(ill_1), 32'd1);
        acc(1'b1, 3'd2, 32'd2);
        acc(1'b1, 3'd1, 32'h0001_2040);
        chk("R4 no invalidate for empty entry", 32'(inv_a), 32'd0);
        acc(1'b1, 3'd4, 32'h07);
        acc(1'b0, 3'd1, 32'd0);
        chk("R3 tag readback", rd_a, 32'h0001_2040);
        acc(1'b0, 3'd4, 32'd0);
        chk("R3 tag read loads pid from tid", rd_a, 32'h42);
        chk("R10 level1 pid unchanged", rd_1, 32'd0);
        acc(1'b1, 3'd1, 32'h0001_2040);
        chk("R4 invalidate valid entry", 32'({inv_a, iall_a}), 32'd2);
        chk("R4 invalidate index", 32'(iidx_a), 32'd2);
    endtask

    task automatic t_search_basic;
        search(32'h0001_2345, 1'b0, 32'd2, "R5 R6 hit entry 2");
        search(32'h0001_2345, 1'b1, 32'h8000_0002, "R7 zone 0 denies user");
        acc(1'b1, 3'd4, 32'h43);
        acc(1'b1, 3'd2, 32'd5);
        search(32'h0001_2345, 1'b0, 32'h8000_0005, "R6 tid mismatch miss keeps bits");
    endtask

    task automatic t_search_rules;
        acc(1'b1, 3'd4, 32'h0);
        acc(1'b1, 3'd2, 32'd7);
        acc(1'b1, 3'd1, 32'h0040_01C0);
        acc(1'b1, 3'd0, 32'h10);
        acc(1'b1, 3'd2, 32'd4);
        acc(1'b1, 3'd1, 32'h0040_0040);
        acc(1'b1, 3'd0, 32'h0);
        acc(1'b1, 3'd5, 32'h1000_0000);
        chk("R11 zone word change invalidates", 32'({inv_a, iall_a}), 32'd3);
        acc(1'b1, 3'd4, 32'h99);
        search(32'h0040_FC00, 1'b1, 32'd7, "R6 64K page global tid");
        search(32'h0040_0000, 1'b0, 32'd4, "R5 lowest index wins");
        search(32'h0040_0000, 1'b1, 32'd7, "R7 zone field 1 allows user");
        acc(1'b1, 3'd2, 32'd4);
        acc(1'b1, 3'd0, 32'h50);
        search(32'h0040_0000, 1'b1, 32'd4, "R7 zone beyond count acts as 1");
        search(32'h0080_0000, 1'b0, 32'h8000_0004, "R5 miss sets bit 31");
    endtask

    task automatic t_busy;
        acc(1'b1, 3'd2, 32'd4);
        priv_user = 1'b0;
        acc(1'b1, 3'd3, 32'h0080_0000);
        acc(1'b1, 3'd2, 32'd1);
        chk("R8 no strobe while busy", 32'(ill_a), 32'd0);
        acc(1'b1, 3'd4, 32'h55);
        for (int k = 0; k < 20 && busy_a; k++) @(negedge clk);
        acc(1'b0, 3'd2, 32'd0);
        chk("R8 index write ignored while busy", rd_a, 32'h8000_0004);
        acc(1'b0, 3'd4, 32'd0);
        chk("R8 pid write ignored while busy", rd_a, 32'h99);
    endtask

    task automatic t_pid_zone;
        acc(1'b1, 3'd5, 32'h1000_0000);
        chk("R11 same zone value no invalidate", 32'(inv_a), 32'd0);
        acc(1'b1, 3'd5, 32'h3);
        chk("R11 zone change all", 32'({inv_a, iall_a}), 32'd3);
        acc(1'b1, 3'd4, 32'h1FF);
        chk("R12 wide pid flagged", 32'(perr_a), 32'd1);
        acc(1'b0, 3'd4, 32'd0);
        chk("R12 wide pid stored", rd_a, 32'h1FF);
        acc(1'b1, 3'd4, 32'h1FF);
        chk("R11 same pid no invalidate", 32'(inv_a), 32'd0);
        chk("R12 wide pid flagged again", 32'(perr_a), 32'd1);
    endtask

    task automatic t_gating;
        acc(1'b1, 3'd2, 32'd3);
        chk("R9 off write strobe", 32'(ill_o), 32'd1);
        acc(1'b0, 3'd2, 32'd0);
        chk("R9 off index read zero", rd_o, 32'd0);
        acc(1'b1, 3'd4, 32'h77);
        chk("R9 off no invalidate", 32'(inv_o), 32'd0);
        chk("R10 level2 pid write allowed", 32'(ill_2), 32'd0);
        acc(1'b1, 3'd3, 32'h0);
        chk("R10 level1 search rejected", 32'(ill_1), 32'd1);
        chk("R10 level1 not busy", 32'(busy_1), 32'd0);
        for (int k = 0; k < 20 && busy_a; k++) @(negedge clk);
        acc(1'b0, 3'd5, 32'd0);
        chk("R10 level1 zone write ignored", rd_1, 32'd0);
        chk("R10 level1 zone read allowed", 32'(ill_1), 32'd0);
        acc(1'b0, 3'd4, 32'd0);
        chk("R10 level2 pid read strobe", 32'(ill_2), 32'd1);
        chk("R10 level2 pid read zero", rd_2, 32'd0);
    endtask

    task automatic t_unused;
        acc(1'b1, 3'd2, 32'd9);
        acc(1'b1, 3'd6, 32'hFFFF_FFFF);
        chk("R13 unused write strobe", 32'(ill_a), 32'd1);
        acc(1'b0, 3'd7, 32'd0);
        chk("R13 unused read zero", rd_a, 32'd0);
        chk("R13 unused read strobe", 32'(ill_a), 32'd1);
        acc(1'b0, 3'd2, 32'd0);
        chk("R13 index untouched", rd_a, 32'd9);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_sel = 3'd0;
        acc_wdata = 32'd0; priv_user = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_entry_rw();
        t_tid_pid();
        t_search_basic();
        t_search_rules();
        t_busy();
        t_pid_zone();
        t_gating();
        t_unused();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule